// File: doc/BRIEF.md
# Prioritized Interrupt Vector Encoder

This block arbitrates the eleven interrupt sources of a small DSP core and presents one vector address to it. Each source is conditioned by its own trigger rule. The rules are a level that is followed as it is, a one-cycle strobe that is captured, a change in either direction on a pin, or a falling edge on a pin. Captured requests stay pending until the core accepts them. The core accepts a request by pulsing an accept strobe with the index of that source.

All sources except reset pass through a global enable and then a per-source enable. The highest-priority eligible request is turned into a registered valid flag and a 14-bit vector address. Reset is the only source whose vector sits in the ROM region (0x2000). Every other vector lies in low RAM.

Top module: `irq_vector_encoder`

## Requirements
- R1: Priority index 0 is the highest and 10 the lowest. The index, source and vector of each source are: 0 reset 0x2000, 1 power-down 0x002C, 2 host 0x0004, 3 I/O pin 0x0008, 4 card power-down 0x000C, 5 serial 0 transmit 0x0010, 6 serial 0 receive 0x0014, 7 ring 0x0018, 8 serial 1 transmit 0x0020, 9 serial 1 receive 0x0024, 10 timer 0x0028. When several requests are eligible, the one with the lowest index wins.
- R2: `rst_req` is a level request. It is never gated by `glob_en` or `src_en`, and it stops being requested as soon as the input drops.
- R3: A high cycle on `pd_wr`, `host_wr`, `sp0_tx`, `sp0_rx`, `sp1_tx`, `sp1_rx` or `timer_tick` captures a pending request for that source.
- R4: Every change of `gpio0` captures a pending request for source 3, whether the pin rises or falls.
- R5: A falling edge on `ring_n` captures a pending request for source 7. A rising edge has no effect.
- R6: Source 4 is requested exactly while `card_pd_bit` is 1 or `card_pd_n` is 0. An accept strobe for index 4 has no effect on it.
- R7: `ack_valid` with `ack_idx` clears the captured request of that index on the clock edge. Requests of other indices are kept. If a new trigger event for the same source arrives in the same cycle, the request stays pending.
- R8: With `glob_en` low, or with `src_en[i]` low, source i (1 to 10) is not selected. A captured request stays pending while it is masked and is selected once it is enabled again.
- R9: The outputs are registered. A level input appears on the outputs one edge after it changes. A strobe or pin event appears two edges after it arrives: one edge to capture it and one to register the output. `vec_addr` is 0 whenever `vec_valid` is 0.
- R10: A synchronous high `rst` clears all captured requests and drives `vec_valid` and `vec_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req | input | 1 | Reset interrupt request, level |
| pd_wr | input | 1 | Strobe from a write of 1 to the power-down control bit |
| host_wr | input | 1 | Host interrupt strobe |
| gpio0 | input | 1 | I/O pin 0, both edges trigger |
| card_pd_bit | input | 1 | Card power-down status bit, level |
| card_pd_n | input | 1 | Card power-down pin, active low |
| sp0_tx | input | 1 | Serial port 0 transmit strobe |
| sp0_rx | input | 1 | Serial port 0 receive strobe |
| ring_n | input | 1 | Ring pin, falling edge triggers |
| sp1_tx | input | 1 | Serial port 1 transmit strobe |
| sp1_rx | input | 1 | Serial port 1 receive strobe |
| timer_tick | input | 1 | Timer strobe |
| glob_en | input | 1 | Global enable for sources 1 to 10 |
| src_en | input | 10 | Per-source enable; bit i belongs to priority index i (bits 10:1) |
| ack_valid | input | 1 | Accept strobe from the core |
| ack_idx | input | 4 | Priority index being accepted |
| vec_valid | output | 1 | An eligible request is pending |
| vec_addr | output | 14 | Vector address of the winner, 0 when not valid |

## Verification
The accept clear and a fresh trigger event for the same source can land in the same cycle. The bench provokes this by raising `timer_tick` while `ack_valid` names index 10, and then expects the timer vector to remain on the outputs two edges later. A second case pairs an accept for index 9 with a pending timer request, and the timer request must survive. The bench also accepts the level-driven card power-down source while its condition holds, and judges by the vector that is still presented.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int NUM_SRC = 11;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int VEC_W   = 14;

    typedef enum logic [1:0] {
        TRIG_LEVEL,
        TRIG_STROBE,
        TRIG_ANY_EDGE,
        TRIG_FALL
    } trig_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] addr;
    } vec_out_t;

    function automatic trig_e trig_of(input int idx);
        case (idx)
            0, 4:    return TRIG_LEVEL;
            3:       return TRIG_ANY_EDGE;
            7:       return TRIG_FALL;
            default: return TRIG_STROBE;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    return 14'h2000;
            4'd1:    return 14'h002C;
            4'd2:    return 14'h0004;
            4'd3:    return 14'h0008;
            4'd4:    return 14'h000C;
            4'd5:    return 14'h0010;
            4'd6:    return 14'h0014;
            4'd7:    return 14'h0018;
            4'd8:    return 14'h0020;
            4'd9:    return 14'h0024;
            4'd10:   return 14'h0028;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_trigger.sv
module irq_trigger
    import irq_vec_pkg::*;
#(
    parameter trig_e TRIG = TRIG_STROBE
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    input  logic clr,
    output logic req
);

    logic prev_q;
    logic hit;
    logic pend_q;

    always_ff @(posedge clk) prev_q <= sig;

    always_comb begin
        case (TRIG)
            TRIG_ANY_EDGE: hit = sig ^ prev_q;
            TRIG_FALL:     hit = prev_q & ~sig;
            default:       hit = sig;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)      pend_q <= 1'b0;
        else if (hit) pend_q <= 1'b1;
        else if (clr) pend_q <= 1'b0;
    end

    assign req = pend_q;

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        clr && !hit |=> !req);

    // R3
    event_captured_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> req);

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_vec_pkg::*;
#(
    parameter int N = NUM_SRC,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] elig,
    output logic         found,
    output logic [W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && elig[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vector_encoder.sv
module irq_vector_encoder
    import irq_vec_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rst_req,
    input  logic                   pd_wr,
    input  logic                   host_wr,
    input  logic                   gpio0,
    input  logic                   card_pd_bit,
    input  logic                   card_pd_n,
    input  logic                   sp0_tx,
    input  logic                   sp0_rx,
    input  logic                   ring_n,
    input  logic                   sp1_tx,
    input  logic                   sp1_rx,
    input  logic                   timer_tick,
    input  logic                   glob_en,
    input  logic [NUM_SRC-1:1]     src_en,
    input  logic                   ack_valid,
    input  logic [IDX_W-1:0]       ack_idx,
    output logic                   vec_valid,
    output logic [VEC_W-1:0]       vec_addr
);

    logic [NUM_SRC-1:0] src_sig;
    logic [NUM_SRC-1:0] src_req;
    logic [NUM_SRC-1:0] elig;
    logic               found;
    logic [IDX_W-1:0]   win_idx;
    vec_out_t           vec_q;

    assign src_sig = {timer_tick, sp1_rx, sp1_tx, ring_n, sp0_rx, sp0_tx,
                      card_pd_bit | ~card_pd_n, gpio0, host_wr, pd_wr, rst_req};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (trig_of(i) == TRIG_LEVEL) begin : g_lvl
            assign src_req[i] = src_sig[i];
        end else begin : g_lat
            logic clr;
            assign clr = ack_valid && (ack_idx == IDX_W'(i));
            irq_trigger #(.TRIG(trig_of(i))) u_trig (
                .clk (clk),
                .rst (rst),
                .sig (src_sig[i]),
                .clr (clr),
                .req (src_req[i])
            );
        end
    end

    assign elig[0]           = 1'b1;
    assign elig[NUM_SRC-1:1] = glob_en ? src_en : '0;

    irq_pick #(.N(NUM_SRC)) u_pick (
        .req   (src_req),
        .elig  (elig),
        .found (found),
        .idx   (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else begin
            vec_q.valid <= found;
            vec_q.addr  <= found ? vec_of(win_idx) : '0;
        end
    end

    assign vec_valid = vec_q.valid;
    assign vec_addr  = vec_q.addr;

    // R2
    reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(rst_req) |-> vec_valid && vec_addr == 14'h2000);

    // R8
    global_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(glob_en) && !$past(rst_req) |-> !vec_valid);

    // R9
    idle_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> vec_addr == '0);

    // R1
    valid_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && vec_valid |-> $past(|(src_req & elig)));

endmodule

// File: tb/tb_irq_vector_encoder.sv
module tb_irq_vector_encoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_req = 0, pd_wr = 0, host_wr = 0, gpio0 = 0;
    logic        card_pd_bit = 0, card_pd_n = 1;
    logic        sp0_tx = 0, sp0_rx = 0, ring_n = 1, sp1_tx = 0, sp1_rx = 0, timer_tick = 0;
    logic        glob_en = 0;
    logic [10:1] src_en = '0;
    logic        ack_valid = 0;
    logic [3:0]  ack_idx = '0;
    logic        vec_valid;
    logic [13:0] vec_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_encoder dut (
        .clk(clk), .rst(rst), .rst_req(rst_req), .pd_wr(pd_wr), .host_wr(host_wr),
        .gpio0(gpio0), .card_pd_bit(card_pd_bit), .card_pd_n(card_pd_n),
        .sp0_tx(sp0_tx), .sp0_rx(sp0_rx), .ring_n(ring_n), .sp1_tx(sp1_tx),
        .sp1_rx(sp1_rx), .timer_tick(timer_tick), .glob_en(glob_en), .src_en(src_en),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    typedef struct packed {
        logic        ge;
        logic [10:0] en;
        logic [10:0] stb;
        logic        cb;
        logic        cn;
        logic        ev;
        logic [13:0] ea;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t TABLE [NVEC] = '{
        '{1'b1, 11'h7FF, 11'h400, 1'b0, 1'b1, 1'b1, 14'h0028},
        '{1'b1, 11'h7FF, 11'h600, 1'b0, 1'b1, 1'b1, 14'h0024},
        '{1'b1, 11'h7FF, 11'h160, 1'b0, 1'b1, 1'b1, 14'h0010},
        '{1'b1, 11'h7FF, 11'h402, 1'b0, 1'b1, 1'b1, 14'h002C},
        '{1'b1, 11'h7FF, 11'h044, 1'b0, 1'b1, 1'b1, 14'h0004},
        '{1'b1, 11'h7FF, 11'h000, 1'b1, 1'b1, 1'b1, 14'h000C},
        '{1'b1, 11'h7FF, 11'h020, 1'b0, 1'b0, 1'b1, 14'h000C},
        '{1'b1, 11'h7FF, 11'h040, 1'b0, 1'b1, 1'b1, 14'h0014},
        '{1'b0, 11'h7FF, 11'h002, 1'b0, 1'b1, 1'b0, 14'h0000},
        '{1'b1, 11'h7FD, 11'h202, 1'b0, 1'b1, 1'b1, 14'h0024},
        '{1'b1, 11'h000, 11'h004, 1'b0, 1'b1, 1'b0, 14'h0000},
        '{1'b1, 11'h7FF, 11'h000, 1'b0, 1'b1, 1'b0, 14'h0000},
        '{1'b1, 11'h7FB, 11'h104, 1'b0, 1'b1, 1'b1, 14'h0020}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic ev, input logic [13:0] ea);
        n_chk++;
        if (vec_valid !== ev || vec_addr !== ea) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b addr=0x%04h, expected valid=%0b addr=0x%04h",
                     tag, vec_valid, vec_addr, ev, ea);
        end
    endtask

    task automatic drive_strobes(input logic [10:0] s);
        pd_wr = s[1]; host_wr = s[2]; sp0_tx = s[5]; sp0_rx = s[6];
        sp1_tx = s[8]; sp1_rx = s[9]; timer_tick = s[10];
    endtask

    task automatic accept(input logic [3:0] idx);
        ack_valid = 1'b1; ack_idx = idx;
        tick();
        ack_valid = 1'b0;
        tick();
    endtask

    task automatic pulse_timer();
        timer_tick = 1'b1;
        tick();
        timer_tick = 1'b0;
        tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got no finish, expected end of run");
        summary();
    end

    initial begin
        // R10: reset state, with a strobe held during reset
        pd_wr = 1'b1; glob_en = 1'b1; src_en = '1;
        repeat (3) tick();
        check("R10 during reset", 1'b0, 14'h0000);
        pd_wr = 1'b0;
        rst = 1'b0;
        tick(); tick();
        check("R10 after reset", 1'b0, 14'h0000);

        // Table walk: R1 R3 R6 R8
        for (int k = 0; k < NVEC; k++) begin
            rst = 1'b1;
            tick();
            rst = 1'b0;
            glob_en = TABLE[k].ge;
            src_en = TABLE[k].en[10:1];
            card_pd_bit = TABLE[k].cb;
            card_pd_n = TABLE[k].cn;
            drive_strobes(TABLE[k].stb);
            tick();
            drive_strobes('0);
            tick();
            check($sformatf("R1 R3 R6 R8 table entry %0d", k), TABLE[k].ev, TABLE[k].ea);
        end

        rst = 1'b1; card_pd_bit = 0; card_pd_n = 1;
        tick();
        rst = 1'b0;

        // R2: reset request ignores global enable, follows its level
        glob_en = 1'b0; src_en = '0; rst_req = 1'b1;
        tick();
        check("R2 unmaskable", 1'b1, 14'h2000);
        rst_req = 1'b0;
        tick();
        check("R2 level drop", 1'b0, 14'h0000);
        glob_en = 1'b1; src_en = '1;
        pd_wr = 1'b1; rst_req = 1'b1;
        tick();
        pd_wr = 1'b0;
        tick();
        check("R1 reset above power-down", 1'b1, 14'h2000);
        rst_req = 1'b0;
        tick();
        check("R1 power-down next", 1'b1, 14'h002C);
        accept(4'd1);
        check("R7 power-down cleared", 1'b0, 14'h0000);

        // R4: both edges of gpio0
        gpio0 = 1'b1;
        tick(); tick();
        check("R4 rising", 1'b1, 14'h0008);
        accept(4'd3);
        check("R7 gpio cleared", 1'b0, 14'h0000);
        gpio0 = 1'b0;
        tick(); tick();
        check("R4 falling", 1'b1, 14'h0008);
        accept(4'd3);

        // R5: ring falling edge only
        ring_n = 1'b0;
        tick(); tick();
        check("R5 falling", 1'b1, 14'h0018);
        accept(4'd7);
        check("R7 ring cleared", 1'b0, 14'h0000);
        ring_n = 1'b1;
        tick(); tick();
        check("R5 rising ignored", 1'b0, 14'h0000);

        // R7: accept and new event in the same cycle
        pulse_timer();
        check("R3 timer pending", 1'b1, 14'h0028);
        timer_tick = 1'b1; ack_valid = 1'b1; ack_idx = 4'd10;
        tick();
        timer_tick = 1'b0; ack_valid = 1'b0;
        tick();
        check("R7 set beats clear", 1'b1, 14'h0028);
        accept(4'd9);
        check("R7 other index kept", 1'b1, 14'h0028);
        accept(4'd10);
        check("R7 timer cleared", 1'b0, 14'h0000);

        // R6: level source ignores accept
        card_pd_bit = 1'b1;
        tick();
        check("R6 level on", 1'b1, 14'h000C);
        accept(4'd4);
        check("R6 accept no effect", 1'b1, 14'h000C);
        card_pd_bit = 1'b0;
        tick();
        check("R6 level off", 1'b0, 14'h0000);

        // R8: masked request retained
        src_en[10] = 1'b0;
        pulse_timer();
        check("R8 masked", 1'b0, 14'h0000);
        src_en[10] = 1'b1;
        tick();
        check("R8 unmasked keeps pending", 1'b1, 14'h0028);
        accept(4'd10);

        // R9: strobe latency of two edges
        timer_tick = 1'b1;
        tick();
        timer_tick = 1'b0;
        check("R9 not yet visible", 1'b0, 14'h0000);
        tick();
        check("R9 visible second edge", 1'b1, 14'h0028);

        summary();
    end

endmodule